// File: doc/BRIEF.md
# Programmable-Length Serial CRC Unit

This block computes a cyclic redundancy check one bit at a time over a serial frame. Its length runs from 0 to 8 bits, and its polynomial and seed are set through three small configuration registers. In generate mode it follows the last data bit with the CRC bits, most significant first, on a dedicated output. In check mode it takes the received CRC bits that follow the data, compares each with its own remainder, and then reports whether the frame was intact.

A frame opens with a one-cycle `frame_start` pulse. That pulse loads the seed into the shift register. It also freezes the length, the polynomial and the mode for the rest of the frame, so configuration writes during a frame affect only the next one. Data bits are qualified by `din_valid`, and `din_last` marks the final data bit. The physical bus and any message decoding are outside the block.

Top module: `crc_serial_unit`

## Requirements
- R1: After reset the length register holds 4, the polynomial register holds 0x11 and the seed register holds 0x0A. Bit n of the polynomial register, for n below the length, is the tap for x^n, and the x^length term is implied. While in reset and afterwards, until a frame produces them, `crc_valid`, `chk_done` and `chk_ok` are low.
- R2: A write with `cfg_addr` = 0 sets the length, 1 sets the polynomial and 2 sets the seed. A length value above 8 is stored as 8, and a write to address 3 changes nothing.
- R3: `frame_start` loads the seed, masked to the length, into the shift register. It also captures the length, the polynomial and `check_mode` for the frame and clears `chk_ok`. Configuration writes made later in the frame do not change that frame's result.
- R4: Each data bit accepted in a frame updates the register r of length L as follows: fb = din xor r[L-1], then r becomes (r shifted left by one, kept to L bits) xor (poly[L-1:0] if fb is 1). Data is sent most significant bit first.
- R5: In generate mode (`check_mode` = 0), starting in the cycle after the last data bit, `crc_valid` is high for exactly L cycles. During those cycles `crc_bit` carries r[L-1] down to r[0].
- R6: In generate mode with L = 0, `crc_valid` never rises.
- R7: In check mode (`check_mode` = 1), the next L valid bits after the last data bit are compared in order with r[L-1] down to r[0]. In the cycle after the last compared bit, `chk_done` pulses for one cycle, and `chk_ok` is 1 only if every bit matched.
- R8: In check mode with L = 0, `chk_done` pulses in the cycle after the last data bit with `chk_ok` = 1.
- R9: `chk_ok` holds its value until the next `frame_start`. `din_valid` outside a frame produces no `crc_valid` and no `chk_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 length, 1 polynomial, 2 seed, 3 unused |
| cfg_wdata | input | 8 | Configuration write data |
| check_mode | input | 1 | 0 generate, 1 check; captured at frame start |
| frame_start | input | 1 | One-cycle pulse opening a frame |
| din | input | 1 | Serial data or received CRC bit |
| din_valid | input | 1 | Qualifies `din` |
| din_last | input | 1 | Marks the last data bit (with `din_valid`) |
| crc_bit | output | 1 | Generated CRC bit, MSB first |
| crc_valid | output | 1 | `crc_bit` is valid |
| chk_done | output | 1 | One-cycle pulse when a check completes |
| chk_ok | output | 1 | Result of the last completed check |

## Verification
Frames are run across lengths 1, 2, 3, 4, 5 and 8, with polynomials that have single taps and many taps, with zero, all-ones and mixed seeds, and with data from 3 to 16 bits. A wrong tap mask, a wrong seed load or an off-by-one in the length all show up as a different remainder. Check-mode frames are sent both with a correct CRC and with the first CRC bit inverted, which tells a real comparator apart from one that always passes. Directed frames cover the reset defaults, the saturation of oversized lengths, writes to the unused address, writes in the middle of a frame, zero-length frames in both modes, and how long `chk_ok` is held.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
  localparam int unsigned CRC_MAX_W = 8;
  localparam int unsigned LEN_W     = $clog2(CRC_MAX_W + 1);

  typedef logic [CRC_MAX_W-1:0] crc_vec_t;
  typedef logic [LEN_W-1:0]     crc_len_t;

  localparam crc_len_t DEF_LEN  = crc_len_t'(4);
  localparam crc_vec_t DEF_POLY = crc_vec_t'(8'h11);
  localparam crc_vec_t DEF_SEED = crc_vec_t'(8'h0A);

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_TAIL} frame_st_t;

  function automatic crc_vec_t len_mask(input crc_len_t len);
    crc_vec_t m;
    for (int i = 0; i < CRC_MAX_W; i++) m[i] = (i < int'(len));
    return m;
  endfunction

  function automatic logic bit_at(input crc_vec_t r, input crc_len_t idx1);
    logic b;
    b = 1'b0;
    for (int i = 0; i < CRC_MAX_W; i++)
      if (i == int'(idx1) - 1) b = r[i];
    return b;
  endfunction

  function automatic crc_vec_t crc_step(input crc_vec_t r, input logic d,
                                        input crc_vec_t poly, input crc_len_t len);
    crc_vec_t m;
    logic     fb;
    m  = len_mask(len);
    fb = d ^ bit_at(r, len);
    if (len == '0) return r;
    return ((r << 1) & m) ^ (fb ? (poly & m) : '0);
  endfunction
endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_serial_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [1:0]     addr,
  input  logic [7:0]     wdata,
  output crc_len_t       len_q,
  output crc_vec_t       poly_q,
  output crc_vec_t       seed_q
);
  localparam logic [7:0] LEN_CAP = 8'(CRC_MAX_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= DEF_LEN;
      poly_q <= DEF_POLY;
      seed_q <= DEF_SEED;
    end else if (we) begin
      case (addr)
        2'd0: len_q  <= (wdata > LEN_CAP) ? crc_len_t'(CRC_MAX_W) : crc_len_t'(wdata);
        2'd1: poly_q <= crc_vec_t'(wdata);
        2'd2: seed_q <= crc_vec_t'(wdata);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core
  import crc_serial_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  crc_vec_t seed,
  input  crc_len_t load_len,
  input  logic     shift_en,
  input  logic     d,
  input  crc_vec_t poly,
  input  crc_len_t len,
  output crc_vec_t rem
);
  always_ff @(posedge clk) begin
    if (!rst_n)        rem <= '0;
    else if (load)     rem <= seed & len_mask(load_len);
    else if (shift_en) rem <= crc_step(rem, d, poly, len);
  end
endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_serial_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_start,
  input  logic     check_mode,
  input  logic     din,
  input  logic     din_valid,
  input  logic     din_last,
  input  crc_len_t cfg_len,
  input  crc_vec_t cfg_poly,
  input  crc_vec_t rem,
  output crc_len_t len_snap,
  output crc_vec_t poly_snap,
  output logic     data_shift,
  output logic     crc_bit,
  output logic     crc_valid,
  output logic     chk_done,
  output logic     chk_ok
);
  frame_st_t state;
  crc_len_t  cnt;
  logic      mode_snap;
  logic      mism;
  logic      cur_bit;
  logic      bit_bad;
  logic      tail_last;

  assign data_shift = (state == ST_DATA) && din_valid && !frame_start;
  assign cur_bit    = bit_at(rem, cnt);
  assign bit_bad    = din ^ cur_bit;
  assign tail_last  = (cnt == crc_len_t'(1));
  assign crc_valid  = (state == ST_TAIL) && !mode_snap;
  assign crc_bit    = crc_valid & cur_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      len_snap  <= DEF_LEN;
      poly_snap <= DEF_POLY;
      mode_snap <= 1'b0;
      mism      <= 1'b0;
      chk_done  <= 1'b0;
      chk_ok    <= 1'b0;
    end else begin
      chk_done <= 1'b0;
      if (frame_start) begin
        state     <= ST_DATA;
        len_snap  <= cfg_len;
        poly_snap <= cfg_poly;
        mode_snap <= check_mode;
        mism      <= 1'b0;
        chk_ok    <= 1'b0;
      end else begin
        case (state)
          ST_DATA: if (din_valid && din_last) begin
            if (len_snap == '0) begin
              state <= ST_IDLE;
              if (mode_snap) begin
                chk_done <= 1'b1;
                chk_ok   <= 1'b1;
              end
            end else begin
              state <= ST_TAIL;
              cnt   <= len_snap;
            end
          end
          ST_TAIL: begin
            if (!mode_snap) begin
              cnt <= cnt - crc_len_t'(1);
              if (tail_last) state <= ST_IDLE;
            end else if (din_valid) begin
              cnt <= cnt - crc_len_t'(1);
              if (bit_bad) mism <= 1'b1;
              if (tail_last) begin
                state    <= ST_IDLE;
                chk_done <= 1'b1;
                chk_ok   <= !(mism || bit_bad);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
  import crc_serial_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       check_mode,
  input  logic       frame_start,
  input  logic       din,
  input  logic       din_valid,
  input  logic       din_last,
  output logic       crc_bit,
  output logic       crc_valid,
  output logic       chk_done,
  output logic       chk_ok
);
  crc_len_t cfg_len_q;
  crc_vec_t cfg_poly_q;
  crc_vec_t cfg_seed_q;
  crc_len_t len_snap;
  crc_vec_t poly_snap;
  crc_vec_t rem;
  logic     data_shift;

  crc_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .len_q(cfg_len_q), .poly_q(cfg_poly_q), .seed_q(cfg_seed_q)
  );

  crc_lfsr_core u_core (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .seed(cfg_seed_q),
    .load_len(cfg_len_q), .shift_en(data_shift), .d(din),
    .poly(poly_snap), .len(len_snap), .rem(rem)
  );

  crc_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .check_mode(check_mode),
    .din(din), .din_valid(din_valid), .din_last(din_last),
    .cfg_len(cfg_len_q), .cfg_poly(cfg_poly_q), .rem(rem),
    .len_snap(len_snap), .poly_snap(poly_snap), .data_shift(data_shift),
    .crc_bit(crc_bit), .crc_valid(crc_valid), .chk_done(chk_done), .chk_ok(chk_ok)
  );
endmodule

// File: rtl/crc_serial_unit_chk.sv
module crc_serial_unit_chk
  import crc_serial_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     frame_start,
  input logic     din_last,
  input logic     data_shift,
  input logic     crc_valid,
  input logic     chk_done,
  input logic     chk_ok,
  input crc_len_t cfg_len_q,
  input crc_len_t len_snap
);
  p_len_capped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_len_q <= crc_len_t'(CRC_MAX_W));

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!chk_ok && !crc_valid && !chk_done));

  p_tail_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_valid) |-> $past(data_shift && din_last));

  p_gen_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |-> !chk_done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |=> !chk_done);

  p_zero_len_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_done && len_snap == '0) |-> chk_ok);

  p_ok_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (chk_done || $stable(chk_ok)));
endmodule

bind crc_serial_unit crc_serial_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .din_last(din_last),
  .data_shift(data_shift), .crc_valid(crc_valid), .chk_done(chk_done),
  .chk_ok(chk_ok), .cfg_len_q(cfg_len_q), .len_snap(len_snap)
);

// File: tb/crc_serial_unit_tb.sv
module crc_serial_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {check, corrupt, len[3:0], poly[7:0], seed[7:0], nbits[4:0], data[15:0]}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd4, 8'h11, 8'h0A, 5'd8,  16'h00A5},
    {1'b0, 1'b0, 4'd8, 8'h07, 8'hFF, 5'd16, 16'h1234},
    {1'b0, 1'b0, 4'd3, 8'h03, 8'h05, 5'd5,  16'h001B},
    {1'b0, 1'b0, 4'd1, 8'h01, 8'h00, 5'd7,  16'h0055},
    {1'b1, 1'b0, 4'd4, 8'h13, 8'h0A, 5'd12, 16'h0ABC},
    {1'b1, 1'b0, 4'd8, 8'h1D, 8'h00, 5'd16, 16'hBEEF},
    {1'b1, 1'b1, 4'd5, 8'h05, 8'h1F, 5'd9,  16'h0155},
    {1'b1, 1'b1, 4'd2, 8'h03, 8'h01, 5'd3,  16'h0005}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic check_mode = 1'b0;
  logic frame_start = 1'b0;
  logic din = 1'b0;
  logic din_valid = 1'b0;
  logic din_last = 1'b0;
  logic crc_bit, crc_valid, chk_done, chk_ok;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_serial_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .check_mode(check_mode), .frame_start(frame_start), .din(din), .din_valid(din_valid),
    .din_last(din_last), .crc_bit(crc_bit), .crc_valid(crc_valid),
    .chk_done(chk_done), .chk_ok(chk_ok)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Remainder kept as an integer; the input bit is folded in at the top first.
  function automatic int ref_crc(input int len, input int poly, input int seed,
                                 input int data, input int n);
    int mask, r, top;
    if (len == 0) return 0;
    mask = (1 << len) - 1;
    r = seed & mask;
    for (int i = n - 1; i >= 0; i--) begin
      r = r ^ (((data >> i) & 1) << (len - 1));
      top = (r >> (len - 1)) & 1;
      r = (r << 1) & mask;
      if (top != 0) r = r ^ (poly & mask);
    end
    return r;
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] v);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_frame(input logic m);
    frame_start = 1'b1; check_mode = m;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic drive_bit(input logic d, input logic last);
    din_valid = 1'b1; din = d; din_last = last;
    @(negedge clk);
    din_valid = 1'b0; din_last = 1'b0;
  endtask

  task automatic send_data(input int data, input int n);
    for (int i = n - 1; i >= 0; i--) drive_bit(logic'((data >> i) & 1), i == 0);
  endtask

  task automatic collect_gen(input int len, input int exp, input string req);
    int got = 0;
    bit vld = 1'b1;
    for (int i = 0; i < len; i++) begin
      if (!crc_valid) vld = 1'b0;
      got = (got << 1) | int'(crc_bit);
      @(negedge clk);
    end
    check(vld, {req, " crc_valid high for each CRC bit"}, 0, 1);
    check(got == exp, {req, " generated CRC"}, got, exp);
    check(!crc_valid, {req, " crc_valid drops after L bits"}, int'(crc_valid), 0);
  endtask

  task automatic send_crc(input int len, input int val, input bit corrupt);
    for (int i = len - 1; i >= 0; i--) begin
      logic b = logic'((val >> i) & 1);
      if (corrupt && i == len - 1) b = ~b;
      drive_bit(b, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int exp;
    repeat (3) @(negedge clk);
    // R1: outputs are low while in reset
    check(!crc_valid && !chk_done && !chk_ok, "R1 outputs low in reset",
          {crc_valid, chk_done, chk_ok}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!crc_valid && !chk_done && !chk_ok, "R1 outputs low after reset",
          {crc_valid, chk_done, chk_ok}, 0);

    // R1: defaults L=4, poly 0x11, seed 0x0A
    start_frame(1'b0);
    send_data(32'hC3, 8);
    collect_gen(4, ref_crc(4, 8'h11, 8'h0A, 32'hC3, 8), "R1");

    // R4 R5 R7: vector table
    for (int v = 0; v < NVEC; v++) begin
      logic m = VEC[v][42];
      logic cor = VEC[v][41];
      int len = int'(VEC[v][40:37]);
      int poly = int'(VEC[v][36:29]);
      int seed = int'(VEC[v][28:21]);
      int nb = int'(VEC[v][20:16]);
      int data = int'(VEC[v][15:0]);
      cfg_write(2'd0, 8'(len));
      cfg_write(2'd1, 8'(poly));
      cfg_write(2'd2, 8'(seed));
      exp = ref_crc(len, poly, seed, data, nb);
      start_frame(m);
      send_data(data, nb);
      if (!m) collect_gen(len, exp, "R4 R5");
      else begin
        send_crc(len, exp, cor);
        check(chk_done, "R7 chk_done after CRC bits", int'(chk_done), 1);
        check(chk_ok == !cor, "R7 chk_ok result", int'(chk_ok), int'(!cor));
        @(negedge clk);
        check(!chk_done, "R7 chk_done single cycle", int'(chk_done), 0);
      end
    end

    // R2: oversize length saturates to 8; address 3 has no effect
    cfg_write(2'd0, 8'd12);
    cfg_write(2'd1, 8'h9B);
    cfg_write(2'd2, 8'h55);
    cfg_write(2'd3, 8'h00);
    start_frame(1'b0);
    send_data(32'h6E, 8);
    collect_gen(8, ref_crc(8, 8'h9B, 8'h55, 32'h6E, 8), "R2");

    // R3: writes in the middle of a frame do not touch it
    cfg_write(2'd0, 8'd4);
    cfg_write(2'd1, 8'h13);
    cfg_write(2'd2, 8'h0A);
    start_frame(1'b0);
    for (int i = 7; i >= 4; i--) drive_bit(logic'((32'hB7 >> i) & 1), 1'b0);
    cfg_write(2'd0, 8'd6);
    cfg_write(2'd1, 8'h21);
    for (int i = 3; i >= 0; i--) drive_bit(logic'((32'hB7 >> i) & 1), i == 0);
    collect_gen(4, ref_crc(4, 8'h13, 8'h0A, 32'hB7, 8), "R3");

    // R6: zero length in generate mode
    cfg_write(2'd0, 8'd0);
    start_frame(1'b0);
    send_data(32'h5, 3);
    check(!crc_valid, "R6 no crc_valid at L=0", int'(crc_valid), 0);
    @(negedge clk);
    check(!crc_valid, "R6 no crc_valid at L=0 later", int'(crc_valid), 0);

    // R8: zero length in check mode
    start_frame(1'b1);
    send_data(32'h9, 4);
    check(chk_done && chk_ok, "R8 pass at L=0", {chk_done, chk_ok}, 3);

    // R9: chk_ok held; stray din_valid outside a frame ignored
    for (int i = 0; i < 4; i++) drive_bit(1'b1, 1'b1);
    check(chk_ok && !chk_done && !crc_valid, "R9 held and stray bits ignored",
          {chk_ok, chk_done, crc_valid}, 4);
    start_frame(1'b1);
    check(!chk_ok, "R9 frame_start clears chk_ok", int'(chk_ok), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule